// File: doc/BRIEF.md
# Serial Clock Synthesizer Programmer

This block loads a new frequency setting into an external clock synthesizer. The synthesizer listens to three lines of an 8-bit control byte: a data line, a serial clock line and a strobe line that latches the byte. On a start command the block captures a 5-bit location address and a 13-bit programming word. It saves its current control byte, blanks the display and waits for the clock to settle. It then sends a fixed serial frame, restores the display and the saved byte, waits again, and finally selects the programmed location.

Every wait is built from a cycle counter. The counter is scaled by a parameter that gives the number of clock cycles per millisecond, so the block works at any system clock rate. The host only raises `start_i` and then watches `busy_o` and `done_o`. Each control-byte value the block drives appears on `ctrl_o`, with the strobe in bit 6, the serial clock in bit 3 and the data in bit 2.

Top module: `clksyn_serial_prog`

## Requirements
- R1: After reset, `ctrl_o` is 8'h00 and `blank_o`, `busy_o` and `done_o` are low.
- R2: A start sampled while idle captures `loc_i`, `word_i` and the present `ctrl_o`. In the next cycle `busy_o` and `blank_o` are high and `ctrl_o` is 8'h00.
- R3: The blank phase holds `ctrl_o` at 8'h00 with `blank_o` high for BLANK_MS*CYC_PER_MS cycles before the first serial slot.
- R4: Every serial slot lasts 6 cycles and drives, in order, lo, lo|8'h40, lo, hi, hi|8'h40, hi. The strobe (bit 6) is therefore a one-cycle pulse, with bits 3:0 unchanged in the cycle before and the cycle after it.
- R5: The first slot is a preamble with lo = 8'h00 and hi = 8'h01.
- R6: Then 21 bit slots follow, each with lo = 8'h01|(d<<2) and hi = 8'h09|(d<<2). The bits are sent in this order: 1, 0, 0, then the location address LSB first, then the programming word LSB first.
- R7: After the last slot, its hi value stays on `ctrl_o` with `blank_o` high for TAIL_MS*CYC_PER_MS cycles.
- R8: Next, `blank_o` goes low and `ctrl_o` shows the byte saved at start with bit 6 set, for SETTLE_MS*CYC_PER_MS cycles.
- R9: The closing cycle drives `ctrl_o` to {4'b0, loc[3:0]} with bit 6 set. `busy_o` drops and `done_o` pulses for exactly that cycle. This value stays on `ctrl_o` while idle.
- R10: While busy, a start pulse and any change on `loc_i` or `word_i` have no effect on the outputs.
- R11: `blank_o` is never high unless `busy_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Begin a programming sequence (sampled while idle) |
| loc_i | input | 5 | Location address to program |
| word_i | input | 13 | Programming word |
| ctrl_o | output | 8 | Control byte to the synthesizer (bit 6 strobe, bit 3 serial clock, bit 2 data) |
| blank_o | output | 1 | External display disable |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
A slot or sub-phase counter that is off by one moves a strobe pulse, or changes the data bit under it. This shows on `ctrl_o` in the very cycle of the error, so the cycle-accurate comparison against the reference model catches it at once. A wrong latched address or word shows as a wrong bit 2 on the first affected slot. A timer that counts the wrong length shifts every later cycle, so the mismatch surfaces at the first phase boundary. A lost saved byte is visible for the whole settle phase.

// File: rtl/clksyn_prog_pkg.sv
package clksyn_prog_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_BLANK  = 3'd1,
    ST_SHIFT  = 3'd2,
    ST_TAIL   = 3'd3,
    ST_SETTLE = 3'd4
  } prog_state_e;

  localparam int CTRL_W   = 8;
  localparam int HOLD_POS = 0;
  localparam int DATA_POS = 2;
  localparam int SCLK_POS = 3;
  localparam int STB_POS  = 6;
  localparam int SUBS     = 6;

  localparam logic [CTRL_W-1:0] PRE_LO = 8'h00;
  localparam logic [CTRL_W-1:0] PRE_HI = 8'h01;

  function automatic logic [CTRL_W-1:0] with_strobe(input logic [CTRL_W-1:0] v);
    logic [CTRL_W-1:0] r;
    r = v;
    r[STB_POS] = 1'b1;
    return r;
  endfunction

  function automatic logic [CTRL_W-1:0] bit_lo(input logic d);
    logic [CTRL_W-1:0] r;
    r = '0;
    r[HOLD_POS] = 1'b1;
    r[DATA_POS] = d;
    return r;
  endfunction

  function automatic logic [CTRL_W-1:0] bit_hi(input logic d);
    logic [CTRL_W-1:0] r;
    r = bit_lo(d);
    r[SCLK_POS] = 1'b1;
    return r;
  endfunction

  // Control byte for one sub-phase of a slot; sub 1 and 4 carry the strobe.
  function automatic logic [CTRL_W-1:0] slot_byte(input logic is_pre, input logic d,
                                                  input logic [2:0] sub);
    logic [CTRL_W-1:0] lo, hi;
    lo = is_pre ? PRE_LO : bit_lo(d);
    hi = is_pre ? PRE_HI : bit_hi(d);
    case (sub)
      3'd0, 3'd2: return lo;
      3'd1:       return with_strobe(lo);
      3'd4:       return with_strobe(hi);
      default:    return hi;
    endcase
  endfunction

endpackage

// File: rtl/clksyn_delay_timer.sv
module clksyn_delay_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             last_o
);
  logic [CNT_W-1:0] cnt_q;

  assign last_o = run_i && (cnt_q == len_i - CNT_W'(1));

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !run_i || last_o) cnt_q <= '0;
    else                             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/clksyn_frame_shifter.sv
module clksyn_frame_shifter
  import clksyn_prog_pkg::*;
#(
  parameter int FRAME_W = 21
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic              strobe_o,
  output logic              last_o
);
  localparam int SLOTS  = FRAME_W + 1;
  localparam int SLOT_W = $clog2(SLOTS + 1);
  localparam logic [SLOT_W-1:0] SLOT_LAST = SLOT_W'(SLOTS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [2:0]        sub_q;
  logic [SLOTS-1:0]  ext;
  logic              sub_last;
  logic              cur_bit;

  // Slot 0 is the preamble; slot k carries frame bit k-1.
  assign ext      = {frame_i, 1'b0};
  assign cur_bit  = ext[slot_q];
  assign sub_last = (sub_q == 3'(SUBS - 1));
  assign last_o   = run_i && sub_last && (slot_q == SLOT_LAST);
  assign strobe_o = run_i && ((sub_q == 3'd1) || (sub_q == 3'd4));
  assign ctrl_o   = run_i ? slot_byte(slot_q == '0, cur_bit, sub_q) : '0;

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !run_i) begin
      sub_q  <= '0;
      slot_q <= '0;
    end else if (sub_last) begin
      sub_q  <= '0;
      slot_q <= slot_q + SLOT_W'(1);
    end else begin
      sub_q  <= sub_q + 3'd1;
    end
  end
endmodule

// File: rtl/clksyn_serial_prog.sv
module clksyn_serial_prog
  import clksyn_prog_pkg::*;
#(
  parameter int          CYC_PER_MS = 100000,
  parameter int          BLANK_MS   = 15,
  parameter int          TAIL_MS    = 1,
  parameter int          SETTLE_MS  = 50,
  parameter int          ADDR_W     = 5,
  parameter int          WORD_W     = 13,
  parameter logic [7:0]  CTRL_RESET = 8'h00
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] loc_i,
  input  logic [WORD_W-1:0] word_i,
  output logic [7:0]        ctrl_o,
  output logic              blank_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int FRAME_W  = 3 + ADDR_W + WORD_W;
  localparam int T_BLANK  = BLANK_MS * CYC_PER_MS;
  localparam int T_TAIL   = TAIL_MS * CYC_PER_MS;
  localparam int T_SETTLE = SETTLE_MS * CYC_PER_MS;
  localparam int CNT_W    = $clog2(T_BLANK + T_TAIL + T_SETTLE + 1);

  prog_state_e       state_q;
  logic [ADDR_W-1:0] loc_q;
  logic [WORD_W-1:0] word_q;
  logic [7:0]        saved_q;
  logic [7:0]        idle_ctrl_q;
  logic              done_q;

  logic              t_run, t_last;
  logic [CNT_W-1:0]  t_len;
  logic              in_shift, stb_evt, shift_last, seq_end;
  logic [7:0]        shift_ctrl;
  logic [FRAME_W-1:0] frame;

  // Frame, LSB first: 1, 0 (start), 0 (write), address, word.
  assign frame    = {word_q, loc_q, 2'b00, 1'b1};
  assign in_shift = (state_q == ST_SHIFT);
  assign t_run    = (state_q == ST_BLANK) || (state_q == ST_TAIL) || (state_q == ST_SETTLE);
  assign seq_end  = (state_q == ST_SETTLE) && t_last;

  always_comb begin
    case (state_q)
      ST_BLANK: t_len = CNT_W'(T_BLANK);
      ST_TAIL:  t_len = CNT_W'(T_TAIL);
      default:  t_len = CNT_W'(T_SETTLE);
    endcase
  end

  clksyn_delay_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (t_run),
    .len_i  (t_len),
    .last_o (t_last)
  );

  clksyn_frame_shifter #(.FRAME_W(FRAME_W)) u_shift (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (in_shift),
    .frame_i  (frame),
    .ctrl_o   (shift_ctrl),
    .strobe_o (stb_evt),
    .last_o   (shift_last)
  );

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      loc_q       <= '0;
      word_q      <= '0;
      saved_q     <= '0;
      idle_ctrl_q <= CTRL_RESET;
      done_q      <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (start_i) begin
          loc_q   <= loc_i;
          word_q  <= word_i;
          saved_q <= idle_ctrl_q;
          state_q <= ST_BLANK;
        end
        ST_BLANK:  if (t_last)     state_q <= ST_SHIFT;
        ST_SHIFT:  if (shift_last) state_q <= ST_TAIL;
        ST_TAIL:   if (t_last)     state_q <= ST_SETTLE;
        ST_SETTLE: if (seq_end) begin
          idle_ctrl_q <= with_strobe({4'b0000, loc_q[3:0]});
          done_q      <= 1'b1;
          state_q     <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    case (state_q)
      ST_BLANK:  ctrl_o = '0;
      ST_SHIFT:  ctrl_o = shift_ctrl;
      ST_TAIL:   ctrl_o = bit_hi(word_q[WORD_W-1]);
      ST_SETTLE: ctrl_o = with_strobe(saved_q);
      default:   ctrl_o = idle_ctrl_q;
    endcase
  end

  assign blank_o = (state_q == ST_BLANK) || in_shift || (state_q == ST_TAIL);
  assign busy_o  = (state_q != ST_IDLE);
  assign done_o  = done_q;
endmodule

// File: rtl/clksyn_prog_chk.sv
module clksyn_prog_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       start_i,
  input logic [7:0] ctrl_o,
  input logic       blank_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       stb_evt,
  input logic       in_shift
);
  assert_strobe_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_evt |=> !stb_evt);

  assert_lines_before_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stb_evt && in_shift) |-> (ctrl_o[3:0] == $past(ctrl_o[3:0])));

  assert_lines_after_strobe_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_evt |=> (ctrl_o[3:0] == $past(ctrl_o[3:0])));

  assert_start_accept_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && blank_o && ctrl_o == 8'h00));

  assert_done_ends_busy_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && $past(busy_o)));

  assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  assert_blank_in_busy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    blank_o |-> busy_o);
endmodule

bind clksyn_serial_prog clksyn_prog_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .ctrl_o   (ctrl_o),
  .blank_o  (blank_o),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .stb_evt  (stb_evt),
  .in_shift (in_shift)
);

// File: tb/clksyn_serial_prog_tb.sv
module clksyn_serial_prog_tb;
  localparam int CPM = 4;
  localparam int T_BLANK = 15 * CPM;
  localparam int T_TAIL = 1 * CPM;
  localparam int T_SETTLE = 50 * CPM;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  loc = '0;
  logic [12:0] word = '0;
  logic [7:0]  ctrl;
  logic        blank, busy, done;

  always #2 clk = ~clk;

  clksyn_serial_prog #(.CYC_PER_MS(CPM)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .loc_i(loc), .word_i(word),
    .ctrl_o(ctrl), .blank_o(blank), .busy_o(busy), .done_o(done)
  );

  typedef struct {
    logic [7:0] c;
    logic       b;
    logic       y;
    logic       d;
    string      tag;
  } exp_t;

  exp_t       q[$];
  logic [7:0] last_ctrl = 8'h00;
  int         errors = 0;
  int         checks = 0;
  int         strobes = 0;
  int         cycles = 0;

  task automatic push(input logic [7:0] c, input logic b, input logic y, input logic d,
                      input string tag);
    exp_t e;
    e.c = c; e.b = b; e.y = y; e.d = d; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic build(input logic [4:0] l, input logic [12:0] w, input logic [7:0] saved);
    logic [7:0] lo, hi;
    logic       d;
    for (int i = 0; i < T_BLANK; i++) push(8'h00, 1, 1, 0, "R3");
    for (int s = 0; s < 22; s++) begin
      if (s == 0) begin
        lo = 8'h00; hi = 8'h01;
      end else begin
        if (s == 1)      d = 1'b1;
        else if (s < 4)  d = 1'b0;
        else if (s < 9)  d = l[s-4];
        else             d = w[s-9];
        lo = 8'h01 + (d ? 8'h04 : 8'h00);
        hi = lo + 8'h08;
      end
      push(lo, 1, 1, 0, s == 0 ? "R5" : "R6");
      push(lo | 8'h40, 1, 1, 0, "R4");
      push(lo, 1, 1, 0, "R4");
      push(hi, 1, 1, 0, s == 0 ? "R5" : "R6");
      push(hi | 8'h40, 1, 1, 0, "R4");
      push(hi, 1, 1, 0, "R4");
    end
    hi = w[12] ? 8'h0D : 8'h09;
    for (int i = 0; i < T_TAIL; i++) push(hi, 1, 1, 0, "R7");
    for (int i = 0; i < T_SETTLE; i++) push(saved | 8'h40, 0, 1, 0, "R8");
    push({4'h0, l[3:0]} | 8'h40, 0, 0, 1, "R9");
  endtask

  // Reference model: accept start only while the model is idle (R2, R10).
  always @(posedge clk) begin
    cycles++;
    if (rst_n && q.size() == 0 && start) build(loc, word, last_ctrl);
  end

  always @(negedge clk) begin
    exp_t e;
    if (!rst_n) begin
      e.c = 8'h00; e.b = 0; e.y = 0; e.d = 0; e.tag = "R1";
      last_ctrl = 8'h00;
    end else if (q.size() > 0) begin
      e = q.pop_front();
      last_ctrl = e.c;
    end else begin
      e.c = last_ctrl; e.b = 0; e.y = 0; e.d = 0; e.tag = "R9";
    end
    checks++;
    if (ctrl !== e.c || blank !== e.b || busy !== e.y || done !== e.d) begin
      errors++;
      $display("FAIL %s: ctrl=%h blank=%b busy=%b done=%b expected ctrl=%h blank=%b busy=%b done=%b",
               e.tag, ctrl, blank, busy, done, e.c, e.b, e.y, e.d);
    end
    if (busy && ctrl[6] && blank) strobes++;
  end

  task automatic run(input logic [4:0] l, input logic [12:0] w, input bit disturb);
    strobes = 0;
    @(negedge clk);
    loc = l; word = w; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      // R10: start pulse and new inputs mid-sequence must change nothing
      repeat (100) @(negedge clk);
      loc = ~l; word = ~w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (50) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    wait (q.size() == 0);
    @(negedge clk);
    checks++;
    if (strobes != 44) begin // R4: two strobes in each of 22 slots
      errors++;
      $display("FAIL R4: strobe count %0d expected 44", strobes);
    end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    run(5'h13, 13'h1A5B, 1'b1);
    run(5'h0C, 13'h0001, 1'b0);
    run(5'h1F, 13'h1FFF, 1'b0);
    run(5'h00, 13'h0000, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog: cycles=%0d expected completion", cycles);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule